// File: doc/BRIEF.md
# Flash Write-Cycle Qualifier

This block sits in front of a flash command decoder and decides, on every bus write, whether that write may reach the decoder. It watches the raw chip-select, read-strobe and write-strobe lines from the host bus along with a digital supply-good flag. All of these pass through a two-flop synchronizer first. The block then measures how long the write cycle stays asserted, rejects glitches that are too short, and refuses writes while the read strobe is active. It also refuses every write while the supply is bad and for a programmable hold-off time after the supply becomes good.

A write cycle lasts exactly as long as chip-select and write-strobe are both low. Either strobe can control the cycle: the one that falls last opens it and the one that rises first closes it. Address and data are taken at the moment the cycle closes. A qualified write leaves the block as a single-cycle accept pulse with the captured address and data. The minimum low time and the hold-off length are parameters counted in clock cycles. With a 100 MHz clock, the defaults are 2 cycles for glitch rejection and 1,000,000 cycles for the 10 ms hold-off.

Top module: `flash_wr_qual`

## Requirements
- R1: A write cycle during which the read strobe `oe_n` is sampled low on any cycle produces no accept pulse.
- R2: A write cycle is the interval in which `ce_n` and `we_n` are both low. It works the same whether `we_n` falls first (chip-select controlled), `ce_n` falls first (write-strobe controlled), or both fall together.
- R3: A write cycle that lasts fewer than `MIN_LOW_CYC` clock cycles gives no accept pulse. One that lasts exactly `MIN_LOW_CYC` cycles or longer gives exactly one.
- R4: While `supply_ok` is low, no write is accepted.
- R5: After `supply_ok` rises, no write is accepted until the hold-off of `POR_CYC` clock cycles has passed.
- R6: A drop of `supply_ok` restarts the hold-off from zero, so a write shortly after the supply recovers is rejected even if the earlier hold-off had finished.
- R7: `wr_accept` is high for exactly one clock cycle per qualified write. Counting edges after the input change, it rises at the third rising clock edge after the controlling strobe goes high.
- R8: `wr_addr` and `wr_data` hold the address and data that were present when the controlling strobe rose. Changes made to them after that moment have no effect on the accepted values.
- R9: While `rst` is high and after it falls, `wr_accept` is 0 and `wr_addr` and `wr_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply-good flag, asynchronous to `clk` |
| ce_n | input | 1 | Chip select, active low, asynchronous |
| oe_n | input | 1 | Read (output) strobe, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| addr | input | ADDR_W (20) | Bus address |
| data | input | DATA_W (16) | Bus write data |
| wr_accept | output | 1 | One-cycle pulse for a qualified write |
| wr_addr | output | ADDR_W (20) | Address of the last qualified write |
| wr_data | output | DATA_W (16) | Data of the last qualified write |

## Verification
Input changes are made on falling clock edges. The accept pulse for a qualified write is therefore due on the third rising edge after the controlling strobe rises: two edges for the synchronizer and one for the output register. The driver records that cycle number alongside the expected address and data. The monitor samples on falling edges, compares each accept against the oldest queued entry, and flags any pulse that arrives in a different cycle or with no pending entry. For rejected writes, the driver waits six cycles after the strobes rise and then confirms that the accept count has not changed. The hold-off tests override the hold-off to 200 cycles, and then wait well beyond it or stay well short of it.

// File: rtl/wq_pkg.sv
package wq_pkg;
    localparam int ADDR_W    = 20;
    localparam int DATA_W    = 16;
    localparam int SYNC_DEPTH = 2;

    // Control lines after synchronization
    typedef struct packed {
        logic supply_ok;
        logic ce_n;
        logic oe_n;
        logic we_n;
    } ctl_t;

    // Idle values: supply bad, all strobes inactive (high)
    localparam ctl_t CTL_IDLE = '{supply_ok: 1'b0, ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1};

    // Payload carried with a write
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_word_t;

    localparam int WORD_W = $bits(wr_word_t);

    // Saturating increment toward a limit
    function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] lim);
        return (v < lim) ? v + 32'd1 : lim;
    endfunction
endpackage

// File: rtl/wq_delay.sv
module wq_delay #(
    parameter int W      = 4,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                stage_q[i] <= RST_VAL;
            else if (i == 0)
                stage_q[i] <= din;
            else
                stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/wq_por_timer.sv
module wq_por_timer #(
    parameter int POR_CYC = 1_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok_s,
    output logic ready
);
    localparam int CW = $clog2(POR_CYC + 1);
    localparam logic [CW-1:0] LIM = CW'(POR_CYC);

    logic [CW-1:0] hold_cnt;

    always_ff @(posedge clk) begin
        if (rst || !supply_ok_s)
            hold_cnt <= '0;
        else
            hold_cnt <= CW'(wq_pkg::sat_inc(32'(hold_cnt), 32'(POR_CYC)));
    end

    assign ready = (hold_cnt == LIM);

    // A supply drop must clear readiness on the next cycle
    assert_supply_low_clears_R6: assert property (@(posedge clk) disable iff (rst)
        !supply_ok_s |=> !ready);
endmodule

// File: rtl/wq_cycle_qual.sv
module wq_cycle_qual #(
    parameter int MIN_LOW_CYC = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  wq_pkg::ctl_t     ctl_s,
    input  wq_pkg::wr_word_t word_s,
    input  logic             por_ready,
    output logic             accept,
    output wq_pkg::wr_word_t accepted
);
    localparam int CW = $clog2(MIN_LOW_CYC + 1);
    localparam logic [CW-1:0] LIM = CW'(MIN_LOW_CYC);

    logic          in_cycle;
    logic          cyc_open;
    logic [CW-1:0] low_cnt;
    logic          inhibit;
    logic          closing;
    logic          pass;

    assign in_cycle = !ctl_s.ce_n && !ctl_s.we_n;
    assign closing  = cyc_open && !in_cycle;
    assign pass     = closing && !inhibit && por_ready && (low_cnt == LIM);

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_open <= 1'b0;
            low_cnt  <= '0;
            inhibit  <= 1'b0;
            accept   <= 1'b0;
            accepted <= '0;
        end else begin
            accept <= pass;
            if (pass)
                accepted <= word_s;
            if (in_cycle) begin
                cyc_open <= 1'b1;
                low_cnt  <= cyc_open ? CW'(wq_pkg::sat_inc(32'(low_cnt), 32'(MIN_LOW_CYC))) : CW'(1);
                inhibit  <= (cyc_open && inhibit) || !ctl_s.oe_n || !ctl_s.supply_ok || !por_ready;
            end else begin
                cyc_open <= 1'b0;
            end
        end
    end

    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (rst)
        accept |=> !accept);
    assert_min_width_R3: assert property (@(posedge clk) disable iff (rst)
        accept |-> $past(low_cnt) == LIM);
    assert_oe_inhibit_R1: assert property (@(posedge clk) disable iff (rst)
        (in_cycle && !ctl_s.oe_n) |=> (!accept && cyc_open) || !cyc_open);
endmodule

// File: rtl/flash_wr_qual.sv
module flash_wr_qual #(
    parameter int MIN_LOW_CYC = 2,
    parameter int POR_CYC     = 1_000_000
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      supply_ok,
    input  logic                      ce_n,
    input  logic                      oe_n,
    input  logic                      we_n,
    input  logic [wq_pkg::ADDR_W-1:0] addr,
    input  logic [wq_pkg::DATA_W-1:0] data,
    output logic                      wr_accept,
    output logic [wq_pkg::ADDR_W-1:0] wr_addr,
    output logic [wq_pkg::DATA_W-1:0] wr_data
);
    import wq_pkg::*;

    ctl_t     ctl_raw, ctl_s;
    wr_word_t word_raw, word_s, word_acc;
    logic     por_ready;

    assign ctl_raw  = '{supply_ok: supply_ok, ce_n: ce_n, oe_n: oe_n, we_n: we_n};
    assign word_raw = '{addr: addr, data: data};

    // Strobes through the synchronizer
    wq_delay #(.W($bits(ctl_t)), .STAGES(SYNC_DEPTH), .RST_VAL(CTL_IDLE)) u_ctl_sync (
        .clk(clk), .rst(rst), .din(ctl_raw), .dout(ctl_s)
    );

    // Payload delayed by the same depth so it lines up with the strobes
    wq_delay #(.W(WORD_W), .STAGES(SYNC_DEPTH), .RST_VAL('0)) u_word_pipe (
        .clk(clk), .rst(rst), .din(word_raw), .dout(word_s)
    );

    wq_por_timer #(.POR_CYC(POR_CYC)) u_por (
        .clk(clk), .rst(rst), .supply_ok_s(ctl_s.supply_ok), .ready(por_ready)
    );

    wq_cycle_qual #(.MIN_LOW_CYC(MIN_LOW_CYC)) u_qual (
        .clk(clk), .rst(rst), .ctl_s(ctl_s), .word_s(word_s),
        .por_ready(por_ready), .accept(wr_accept), .accepted(word_acc)
    );

    assign wr_addr = word_acc.addr;
    assign wr_data = word_acc.data;

    assert_accept_after_holdoff_R5: assert property (@(posedge clk) disable iff (rst)
        wr_accept |-> $past(por_ready));
    assert_supply_blocks_R4: assert property (@(posedge clk) disable iff (rst)
        !ctl_s.supply_ok |=> !wr_accept);
endmodule

// File: tb/flash_wr_qual_tb.sv
module flash_wr_qual_tb;
    localparam int MIN_W = 3;
    localparam int POR_W = 200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        supply_ok = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [19:0] addr = '0;
    logic [15:0] data = '0;
    logic        wr_accept;
    logic [19:0] wr_addr;
    logic [15:0] wr_data;

    flash_wr_qual #(.MIN_LOW_CYC(MIN_W), .POR_CYC(POR_W)) u_dut (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .ce_n(ce_n), .oe_n(oe_n),
        .we_n(we_n), .addr(addr), .data(data), .wr_accept(wr_accept),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [19:0] a;
        logic [15:0] d;
        int          due;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   n_chk = 0, n_fail = 0, n_acc = 0;
    bit   finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare each accept pulse with the oldest expectation
    always @(negedge clk) begin
        if (!rst && wr_accept) begin
            n_acc++;
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected accept (R1/R3/R4/R5/R6): got addr=%h data=%h cyc=%0d, expected none",
                         wr_addr, wr_data, cyc);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (wr_addr !== e.a || wr_data !== e.d || cyc != e.due) begin
                    n_fail++;
                    $display("FAIL %s R7 R8: got addr=%h data=%h cyc=%0d, expected addr=%h data=%h cyc=%0d",
                             e.req, wr_addr, wr_data, cyc, e.a, e.d, e.due);
                end
            end
        end
    end

    task automatic check(input bit ok, input string msg, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", msg, act, expv);
        end
    endtask

    // mode 0: both fall together; 1: we falls first, ce controls; 2: ce falls first, we controls
    task automatic wcycle(input int mode, input int overlap, input bit oe_low,
                          input logic [19:0] a, input logic [15:0] d,
                          input bit expect_ok, input string req);
        int acc0;
        acc0 = n_acc;
        @(negedge clk);
        addr = a; data = d;
        if (mode == 1) we_n = 1'b0;
        if (mode == 2) ce_n = 1'b0;
        repeat (2) @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0;
        if (oe_low) oe_n = 1'b0;
        repeat (overlap) @(negedge clk);
        // raise the controlling strobe
        if (mode == 2) we_n = 1'b1; else ce_n = 1'b1;
        if (expect_ok) exp_q.push_back('{a: a, d: d, due: cyc + 3, req: req});
        @(negedge clk);
        addr = ~a; data = ~d;
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        repeat (6) @(negedge clk);
        if (!expect_ok)
            check(n_acc == acc0, {req, " write rejected"}, n_acc - acc0, 0);
        else
            check(n_acc == acc0 + 1, {req, " exactly one accept"}, n_acc - acc0, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R9: outputs during reset
        check(wr_accept === 1'b0 && wr_addr === '0 && wr_data === '0, "R9 reset outputs", int'(wr_accept), 0);
        rst = 1'b0;
        @(negedge clk);
        check(wr_accept === 1'b0 && wr_addr === '0, "R9 after reset", int'(wr_addr), 0);

        // R4: supply bad
        wcycle(0, 5, 1'b0, 20'h11111, 16'h1111, 1'b0, "R4");

        // R5: inside hold-off
        supply_ok = 1'b1;
        wcycle(0, 5, 1'b0, 20'h22222, 16'h2222, 1'b0, "R5");
        repeat (POR_W + 20) @(negedge clk);
        wcycle(0, 5, 1'b0, 20'h33333, 16'h3333, 1'b1, "R5 after hold-off");

        // R2: each controlling strobe
        wcycle(1, 4, 1'b0, 20'h4A5A5, 16'hBEEF, 1'b1, "R2 ce-controlled");
        wcycle(2, 4, 1'b0, 20'h5C3C3, 16'hCAFE, 1'b1, "R2 we-controlled");

        // R3: width boundaries
        wcycle(0, MIN_W - 1, 1'b0, 20'h66666, 16'h6666, 1'b0, "R3 short");
        wcycle(1, 1, 1'b0, 20'h67676, 16'h6767, 1'b0, "R3 glitch");
        wcycle(0, MIN_W, 1'b0, 20'h77777, 16'h7777, 1'b1, "R3 exact");
        wcycle(2, MIN_W + 10, 1'b0, 20'h78787, 16'h7878, 1'b1, "R3 long");

        // R1: read strobe active
        wcycle(0, 5, 1'b1, 20'h88888, 16'h8888, 1'b0, "R1");
        wcycle(0, 5, 1'b0, 20'h89898, 16'h8989, 1'b1, "R1 recovered");

        // R8: payload
        wcycle(0, 4, 1'b0, 20'hFFFFF, 16'h0001, 1'b1, "R8");

        // R6: supply drop restarts hold-off
        @(negedge clk); supply_ok = 1'b0;
        repeat (3) @(negedge clk); supply_ok = 1'b1;
        repeat (10) @(negedge clk);
        wcycle(0, 5, 1'b0, 20'h99999, 16'h9999, 1'b0, "R6");
        repeat (POR_W + 20) @(negedge clk);
        wcycle(1, 5, 1'b0, 20'hAAAAA, 16'hAAAA, 1'b1, "R6 after restart");

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R7 all accepts arrived", exp_q.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule